// File: doc/BRIEF.md
# Peak-Power Assist Mode Controller

This block decides when a battery charger runs in its peak-power assist mode. In this mode the battery helps the adapter feed the system. The host asks for the mode by driving a request pin high while a host disable bit is clear. Dropping the pin or setting the bit asks the block to leave the mode in the normal way. A fault summary vector can end the mode at any time. A fault-forced exit latches an exit flag. The flag pulls the active-low processor-hot output low until the host clears it.

While the mode is active, the block turns off four input regulation functions: input voltage regulation, input current regulation, the critical current trip and the external current limit pin. It also forces two power-monitor source enables, adapter-good monitoring off and system-voltage monitoring on. The monitor settings the host had chosen before entry are saved and put back on exit. After a fault exit the mode stays locked out until the fault has cleared and the request pin has been seen low. This stops the mode from re-entering at once.

All outputs are registered. A decision taken on the inputs present before a rising clock edge is visible just after that edge.

Top module: `assist_mode_ctrl`

## Requirements
- R1: When the mode is off and not locked out, the request pin is 1, the disable bit is 0 and no fault bit is set at a clock edge, `assist_on` is 1 after that edge.
- R2: With the disable bit at 1 or the request pin at 0, the mode is not entered, and `assist_on` stays 0.
- R3: While active, if the request pin is 0 or the disable bit is 1 and no fault bit is set, `assist_on` is 0 after the next edge and `exit_flag` keeps its value.
- R4: While active, any set bit of `fault_vec` makes `assist_on` 0 and `exit_flag` 1 after the next edge, whatever the request pin, the disable bit or `exit_clr` do in that cycle.
- R5: On the edge that enters the mode, `reg_en` becomes all zeros, `acok_mon_en` becomes 0 and `sys_mon_en` becomes 1.
- R6: On the edge that leaves the mode, for either kind of exit, `reg_en` becomes all ones and the two monitor enables return to the values they had just before entry.
- R7: A monitor write (`mon_we` = 1, `mon_wdata[0]` for adapter-good monitoring, `mon_wdata[1]` for system monitoring) takes effect at the next edge while the mode is off. It is ignored while the mode is active. A write in the entry cycle replaces the saved copy instead.
- R8: After a fault exit, the mode is not re-entered until an edge sees the fault vector clear and the request pin at 0.
- R9: `proc_hot_n` is the inverse of `exit_flag`, and a set `exit_flag` does not block entry.
- R10: `exit_clr` at an edge clears `exit_flag`, unless a fault exit happens at that same edge.
- R11: A set fault bit blocks entry from the off state and does not set `exit_flag`.
- R12: After reset, `assist_on` and `exit_flag` are 0, `proc_hot_n` is 1, `reg_en` is all ones, `acok_mon_en` is 1 and `sys_mon_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_pin | input | 1 | Mode request pin from the host |
| host_dis | input | 1 | Host disable bit; 1 forbids or ends the mode |
| fault_vec | input | FAULT_W | Fault summary, one bit per fault source |
| exit_clr | input | 1 | Host clear of the exit flag |
| mon_we | input | 1 | Host write strobe for the monitor enables |
| mon_wdata | input | 2 | Monitor enables to write: bit 0 adapter-good, bit 1 system |
| assist_on | output | 1 | Mode status |
| exit_flag | output | 1 | Latched fault-exit flag |
| proc_hot_n | output | 1 | Processor-hot output, active low |
| reg_en | output | NUM_REG | Regulation function enables: input voltage, input current, critical trip, limit pin |
| acok_mon_en | output | 1 | Adapter-good monitor source enable |
| sys_mon_en | output | 1 | System-voltage monitor source enable |

## Verification
Entry is tried with the disable bit set, with a fault present and with the exit flag still set. These cases separate what blocks entry from what does not. Exits are driven in three ways: by the disable bit, by the pin, and by faults on different vector bits, once together with a clear. This shows which exits latch the flag and that setting the flag takes priority over clearing it. The lockout is exercised with the pin held high after a fault and then cycled. Monitor writes are made inside and outside the mode with both default and non-default values. This shows that the restored values are the saved copy and not the forced ones.

// File: rtl/assist_pkg.sv
package assist_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_LOCK = 2'd2
    } assist_state_t;

    typedef struct packed {
        assist_state_t state;
        logic          exit_flag;
    } fsm_regs_t;

endpackage

// File: rtl/assist_cmd_qual.sv
module assist_cmd_qual #(
    parameter int FAULT_W = 4
) (
    input  logic               req_pin,
    input  logic               host_dis,
    input  logic [FAULT_W-1:0] fault_vec,
    output logic               cmd,
    output logic               fault_any
);

    assign cmd = req_pin & ~host_dis;

    generate
        if (FAULT_W == 1) begin : g_single
            assign fault_any = fault_vec[0];
        end else begin : g_multi
            assign fault_any = |fault_vec;
        end
    endgenerate

endmodule

// File: rtl/assist_fsm.sv
module assist_fsm
    import assist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_pin,
    input  logic cmd,
    input  logic fault_any,
    input  logic exit_clr,
    output logic active,
    output logic exit_flag,
    output logic enter,
    output logic leave
);

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        enter = 1'b0;
        leave = 1'b0;
        case (fsm_q.state)
            ST_OFF: begin
                if (cmd && !fault_any) begin
                    fsm_d.state = ST_ON;
                    enter       = 1'b1;
                end
            end
            ST_ON: begin
                if (fault_any) begin
                    fsm_d.state = ST_LOCK;
                    leave       = 1'b1;
                end else if (!cmd) begin
                    fsm_d.state = ST_OFF;
                    leave       = 1'b1;
                end
            end
            ST_LOCK: begin
                if (!fault_any && !req_pin) begin
                    fsm_d.state = ST_OFF;
                end
            end
            default: fsm_d.state = ST_OFF;
        endcase
        if (exit_clr) begin
            fsm_d.exit_flag = 1'b0;
        end
        if (fsm_q.state == ST_ON && fault_any) begin
            fsm_d.exit_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_OFF, exit_flag: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign active    = (fsm_q.state == ST_ON);
    assign exit_flag = fsm_q.exit_flag;

    // R4: a fault while active ends the mode and latches the flag
    assert_fault_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fault_any) |=> (!active && exit_flag));

    // R3: a normal exit leaves the flag as it was
    assert_normal_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fault_any && !cmd && !exit_clr) |=> (!active && exit_flag == $past(exit_flag)));

    // R8: locked out while the pin has not been seen low
    assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_LOCK && req_pin) |=> !active);

    // R11: a fault blocks entry
    assert_fault_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && fault_any) |=> !active);

    // R10: a clear without a fault exit drops the flag
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_clr && !(active && fault_any)) |=> !exit_flag);

endmodule

// File: rtl/assist_enable_keeper.sv
module assist_enable_keeper #(
    parameter int NUM_REG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               enter,
    input  logic               leave,
    input  logic               mon_we,
    input  logic [1:0]         mon_wdata,
    output logic [NUM_REG-1:0] reg_en,
    output logic               acok_mon_en,
    output logic               sys_mon_en
);

    localparam logic [NUM_REG-1:0] ALL_ON = {NUM_REG{1'b1}};

    typedef struct packed {
        logic [NUM_REG-1:0] reg_en;
        logic               acok;
        logic               sys;
        logic               saved_acok;
        logic               saved_sys;
    } keep_regs_t;

    keep_regs_t keep_d, keep_q;

    always_comb begin
        keep_d = keep_q;
        if (enter) begin
            keep_d.saved_acok = mon_we ? mon_wdata[0] : keep_q.acok;
            keep_d.saved_sys  = mon_we ? mon_wdata[1] : keep_q.sys;
            keep_d.acok       = 1'b0;
            keep_d.sys        = 1'b1;
            keep_d.reg_en     = '0;
        end else if (leave) begin
            keep_d.acok   = keep_q.saved_acok;
            keep_d.sys    = keep_q.saved_sys;
            keep_d.reg_en = ALL_ON;
        end else if (mon_we && !active) begin
            keep_d.acok = mon_wdata[0];
            keep_d.sys  = mon_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= '{reg_en: ALL_ON, acok: 1'b1, sys: 1'b0,
                        saved_acok: 1'b1, saved_sys: 1'b0};
        end else begin
            keep_q <= keep_d;
        end
    end

    assign reg_en      = keep_q.reg_en;
    assign acok_mon_en = keep_q.acok;
    assign sys_mon_en  = keep_q.sys;

    // R5: entry forces the regulation and monitor overrides
    assert_entry_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (reg_en == '0 && !acok_mon_en && sys_mon_en));

    // R6: exit brings every regulation function back
    assert_exit_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (reg_en == ALL_ON));

    // R7: host writes do not disturb the monitors while active
    assert_hold_monitors_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !leave) |=> ($stable(acok_mon_en) && $stable(sys_mon_en)));

endmodule

// File: rtl/assist_mode_ctrl.sv
module assist_mode_ctrl #(
    parameter int FAULT_W = 4,
    parameter int NUM_REG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_pin,
    input  logic               host_dis,
    input  logic [FAULT_W-1:0] fault_vec,
    input  logic               exit_clr,
    input  logic               mon_we,
    input  logic [1:0]         mon_wdata,
    output logic               assist_on,
    output logic               exit_flag,
    output logic               proc_hot_n,
    output logic [NUM_REG-1:0] reg_en,
    output logic               acok_mon_en,
    output logic               sys_mon_en
);

    logic cmd;
    logic fault_any;
    logic enter;
    logic leave;

    assist_cmd_qual #(.FAULT_W(FAULT_W)) u_qual (
        .req_pin   (req_pin),
        .host_dis  (host_dis),
        .fault_vec (fault_vec),
        .cmd       (cmd),
        .fault_any (fault_any)
    );

    assist_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pin   (req_pin),
        .cmd       (cmd),
        .fault_any (fault_any),
        .exit_clr  (exit_clr),
        .active    (assist_on),
        .exit_flag (exit_flag),
        .enter     (enter),
        .leave     (leave)
    );

    assist_enable_keeper #(.NUM_REG(NUM_REG)) u_keep (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (assist_on),
        .enter       (enter),
        .leave       (leave),
        .mon_we      (mon_we),
        .mon_wdata   (mon_wdata),
        .reg_en      (reg_en),
        .acok_mon_en (acok_mon_en),
        .sys_mon_en  (sys_mon_en)
    );

    assign proc_hot_n = ~exit_flag;

    // R9: processor-hot output mirrors the latched flag
    assert_prochot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proc_hot_n != exit_flag);

endmodule

// File: tb/assist_mode_ctrl_test.sv
`timescale 1ns/100ps
module assist_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_pin = 1'b0;
    logic       host_dis = 1'b0;
    logic [3:0] fault_vec = '0;
    logic       exit_clr = 1'b0;
    logic       mon_we = 1'b0;
    logic [1:0] mon_wdata = '0;
    logic       assist_on, exit_flag, proc_hot_n, acok_mon_en, sys_mon_en;
    logic [3:0] reg_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic       on;
        logic       flag;
        logic [3:0] rg;
        logic       acok;
        logic       sys;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    assist_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .host_dis(host_dis),
        .fault_vec(fault_vec), .exit_clr(exit_clr), .mon_we(mon_we),
        .mon_wdata(mon_wdata), .assist_on(assist_on), .exit_flag(exit_flag),
        .proc_hot_n(proc_hot_n), .reg_en(reg_en), .acok_mon_en(acok_mon_en),
        .sys_mon_en(sys_mon_en)
    );

    task automatic compare(input exp_t e);
        total++;
        if (assist_on !== e.on || exit_flag !== e.flag || proc_hot_n !== ~e.flag ||
            reg_en !== e.rg || acok_mon_en !== e.acok || sys_mon_en !== e.sys) begin
            bad++;
            $display("FAIL %s: got on=%b flag=%b phn=%b reg=%h acok=%b sys=%b exp on=%b flag=%b phn=%b reg=%h acok=%b sys=%b",
                     e.tag, assist_on, exit_flag, proc_hot_n, reg_en, acok_mon_en, sys_mon_en,
                     e.on, e.flag, ~e.flag, e.rg, e.acok, e.sys);
        end
    endtask

    task automatic step(input logic req, input logic dis, input logic [3:0] flt,
                        input logic clr, input logic we, input logic [1:0] wd,
                        input logic e_on, input logic e_flag, input logic [3:0] e_rg,
                        input logic e_acok, input logic e_sys, input string tag);
        exp_t e;
        @(negedge clk);
        req_pin = req; host_dis = dis; fault_vec = flt;
        exit_clr = clr; mon_we = we; mon_wdata = wd;
        e.on = e_on; e.flag = e_flag; e.rg = e_rg; e.acok = e_acok; e.sys = e_sys; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: one result per edge, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            compare(sb.pop_front());
        end
    end

    initial begin
        exp_t r;
        @(posedge clk);
        #1;
        r.on = 0; r.flag = 0; r.rg = 4'hF; r.acok = 1; r.sys = 0; r.tag = "R12 reset state";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        //    req dis flt    clr we wd     on flag reg   acok sys
        step(1, 1, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 1, 0, "R2 disable bit blocks entry");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 1, 0, "R2 pin low blocks entry");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R1 R5 entry with overrides");
        step(1, 0, 4'h0, 0, 1, 2'b00, 1, 0, 4'h0, 0, 1, "R7 write ignored while active");
        step(1, 1, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 1, 0, "R3 R6 normal exit by disable bit");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R1 re-entry after normal exit");
        step(1, 0, 4'h4, 0, 0, 2'b00, 0, 1, 4'hF, 1, 0, "R4 R6 fault exit latches flag");
        step(1, 0, 4'h0, 0, 0, 2'b00, 0, 1, 4'hF, 1, 0, "R8 lockout with pin held high");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 1, 4'hF, 1, 0, "R8 pin seen low");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 1, 4'h0, 0, 1, "R9 flag does not block entry");
        step(1, 0, 4'h0, 1, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R10 host clear drops flag");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 1, 0, "R3 normal exit by pin");
        step(0, 0, 4'h0, 0, 1, 2'b00, 0, 0, 4'hF, 0, 0, "R7 write applied while off");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R5 entry from non-default monitors");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R6 restore non-default monitors");
        step(1, 0, 4'h2, 0, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R11 fault blocks entry, no flag");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R1 entry once fault clears");
        step(1, 0, 4'h1, 1, 0, 2'b00, 0, 1, 4'hF, 0, 0, "R4 fault set wins over clear");
        step(0, 0, 4'h1, 1, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R10 clear during lockout");
        step(1, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R8 fault present when pin was low");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R8 release with pin low");
        step(1, 0, 4'h0, 0, 0, 2'b00, 1, 0, 4'h0, 0, 1, "R1 entry after lockout release");
        step(0, 0, 4'h0, 0, 0, 2'b00, 0, 0, 4'hF, 0, 0, "R6 exit restores saved monitors");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got run still busy exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule